// File: doc/BRIEF.md
# UART Request-To-Send and Multidrop Address Control

This block holds the request-to-send (RTS) state of one UART channel and drives the matching active-low pin. Software moves the state in two ways: with write strobes from a set register and a reset register, and with channel commands. The block can also move it by itself. When receiver flow control is on, the FIFO filling up negates RTS and the FIFO draining reasserts it. When transmitter flow control is on, RTS drops once the final character has left the line, stop bits included. Flow control by the receiver works from the first transition, so software does not have to assert RTS first.

The block also handles multidrop framing. When the transmit holding buffer hands a character to the shift register, the block captures the address/data mode bit and that character together. In multidrop mode it places the captured bit as the ninth bit of the word it passes to the serializer. Software may change the mode bit as soon as the hand-over has happened. The word already in flight keeps the bit it was captured with, so there is no need to stop the transmitter or wait for it to go idle. Baud generation and the serializer itself are outside the block.

Top module: `uart_rts_addr_ctl`

## Requirements
- R1: While rst_n is low, and in the cycle after a module-reset strobe, rts_n_o is 1, ad_latched_o is 0 and frame_o is all zeros. Outputs change on the rising clock edge that samples their cause.
- R2: RTS is asserted (rts_n_o goes to 0 after the next edge) by set_wr_i, or by cmd_valid_i with cmd_i equal to 3'b001.
- R3: RTS is negated (rts_n_o goes to 1 after the next edge) by clr_wr_i, by mod_rst_i, or by cmd_valid_i with cmd_i equal to 3'b010.
- R4: With rx_rts_en_i high, a 0-to-1 change of rxf_full_i between two sampling edges negates RTS.
- R5: With rx_rts_en_i high, a 1-to-0 change of rxf_full_i asserts RTS, with no earlier manual assertion needed.
- R6: With rx_rts_en_i low, rxf_full_i has no effect on rts_n_o. A level that is merely held produces no change even when the enable is high.
- R7: With tx_rts_en_i high, a tx_done_i pulse (last stop bit sent) negates RTS. With the enable low, the pulse has no effect.
- R8: When a set cause and a clear cause occur in the same cycle, the clear wins and rts_n_o ends at 1.
- R9: ad_latched_o takes the value of ad_mode_i only on a cycle with tx_load_i high. Changes to ad_mode_i or tx_char_i at other times leave ad_latched_o and frame_o unchanged.
- R10: On tx_load_i, frame_o[DATA_W-1:0] captures tx_char_i. frame_o[DATA_W] captures ad_mode_i when md_en_i is 1, and 0 when md_en_i is 0.
- R11: A cmd_i code other than 3'b001 or 3'b010, or any code with cmd_valid_i low, leaves rts_n_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_rst_i | input | 1 | Channel module-reset strobe |
| set_wr_i | input | 1 | Write of 1 to the RTS bit of the output-set register |
| clr_wr_i | input | 1 | Write of 1 to the RTS bit of the output-reset register |
| cmd_valid_i | input | 1 | Channel command strobe |
| cmd_i | input | 3 | Command code (001 assert RTS, 010 negate RTS) |
| rx_rts_en_i | input | 1 | Receiver-controlled RTS enable |
| rxf_full_i | input | 1 | Receive FIFO full level |
| tx_rts_en_i | input | 1 | Transmitter-controlled RTS enable |
| tx_done_i | input | 1 | Pulse when the last character and its stop bits have been sent |
| tx_load_i | input | 1 | Pulse when the holding buffer hands a character to the shifter |
| ad_mode_i | input | 1 | Address/data mode bit from the mode register |
| md_en_i | input | 1 | Multidrop mode enable |
| tx_char_i | input | DATA_W | Character in the transmit holding buffer |
| rts_n_o | output | 1 | RTS pin, active low |
| ad_latched_o | output | 1 | Address/data bit captured at the last hand-over |
| frame_o | output | DATA_W+1 | Captured word for the shifter, with the ninth bit on top |

## Verification
The RTS state is a single flag that is visible directly on rts_n_o, so a wrong set, clear or priority decision appears on the pin one edge after its cause. A receive-FIFO history register that holds the wrong value shows up differently. It produces a missing or spurious RTS change at the first FIFO transition, or while the level is held, after the fault. A capture register that loads at the wrong time shows up only after the next change of ad_mode_i or tx_char_i away from a hand-over, as a change on ad_latched_o or frame_o.

// File: rtl/uart_rts_pkg.sv
// Shared constants and types for the RTS and multidrop control block.
// Assumes a 3-bit channel command field. Only two codes touch RTS.
package uart_rts_pkg;
    localparam int CMD_W = 3;
    localparam logic [CMD_W-1:0] CMD_RTS_ON  = 3'b001;
    localparam logic [CMD_W-1:0] CMD_RTS_OFF = 3'b010;

    // Combined requests presented to the RTS flag register
    typedef struct packed {
        logic set_req;
        logic clr_req;
    } rts_req_t;
endpackage

// File: rtl/rts_level_edge.sv
// Detects the rising and falling changes of a level input between two
// sampling edges. Assumes the level is already synchronous to clk. The
// history register resets to 0, so a level that is high out of reset
// counts as a rise.
module rts_level_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    // History of the level at the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    // Change decode against the history
    always_comb begin
        rise_o = level_i & ~prev_q;
        fall_o = ~level_i & prev_q;
    end
endmodule

// File: rtl/rts_src_decode.sv
// Merges every RTS set and clear cause into one request pair. Purely
// combinational. Assumes the strobes are one-cycle pulses and that the
// mode enables are static levels.
module rts_src_decode
    import uart_rts_pkg::*;
(
    input  logic             mod_rst_i,
    input  logic             set_wr_i,
    input  logic             clr_wr_i,
    input  logic             cmd_valid_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             rx_rts_en_i,
    input  logic             rxf_rise_i,
    input  logic             rxf_fall_i,
    input  logic             tx_rts_en_i,
    input  logic             tx_done_i,
    output rts_req_t         req_o
);
    logic cmd_on;
    logic cmd_off;

    // Command code decode
    always_comb begin
        cmd_on  = cmd_valid_i && (cmd_i == CMD_RTS_ON);
        cmd_off = cmd_valid_i && (cmd_i == CMD_RTS_OFF);
    end

    // Gather set and clear causes
    always_comb begin
        req_o.set_req = set_wr_i | cmd_on | (rx_rts_en_i & rxf_fall_i);
        req_o.clr_req = clr_wr_i | mod_rst_i | cmd_off
                      | (rx_rts_en_i & rxf_rise_i)
                      | (tx_rts_en_i & tx_done_i);
    end
endmodule

// File: rtl/rts_flag_reg.sv
// Holds the RTS request flag. Clear has priority over set. The pin is
// the inverse of the flag (active low).
module rts_flag_reg
    import uart_rts_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  rts_req_t req_i,
    output logic     rts_n_o
);
    logic flag_q;

    // Flag update, clear first
    always_ff @(posedge clk) begin
        if (!rst_n)             flag_q <= 1'b0;
        else if (req_i.clr_req) flag_q <= 1'b0;
        else if (req_i.set_req) flag_q <= 1'b1;
    end

    // Active-low pin drive
    assign rts_n_o = ~flag_q;
endmodule

// File: rtl/ad_frame_latch.sv
// Captures the address/data mode bit and the outgoing character at the
// buffer-to-shifter hand-over, and forms the widened word. Assumes
// tx_load_i is a single-cycle pulse. A module reset takes priority over
// a capture in the same cycle.
module ad_frame_latch #(
    parameter int DATA_W = 8,
    localparam int FRAME_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_rst_i,
    input  logic              tx_load_i,
    input  logic              ad_mode_i,
    input  logic              md_en_i,
    input  logic [DATA_W-1:0] tx_char_i,
    output logic              ad_latched_o,
    output logic [FRAME_W-1:0] frame_o
);
    logic               ad_q;
    logic [FRAME_W-1:0] frame_q;
    logic               ninth_bit;

    // Ninth bit carries the address/data flag only in multidrop mode
    assign ninth_bit = md_en_i & ad_mode_i;

    // Capture at hand-over, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || mod_rst_i) begin
            ad_q    <= 1'b0;
            frame_q <= '0;
        end else if (tx_load_i) begin
            ad_q    <= ad_mode_i;
            frame_q <= {ninth_bit, tx_char_i};
        end
    end

    assign ad_latched_o = ad_q;
    assign frame_o      = frame_q;
endmodule

// File: rtl/uart_rts_addr_ctl.sv
// Top of the RTS and multidrop control for one UART channel. It ties
// the FIFO level change detector, the cause decoder, the RTS flag and
// the address/data capture together. Assumes all inputs are synchronous
// to clk.
module uart_rts_addr_ctl
    import uart_rts_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_rst_i,
    input  logic              set_wr_i,
    input  logic              clr_wr_i,
    input  logic              cmd_valid_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic              rx_rts_en_i,
    input  logic              rxf_full_i,
    input  logic              tx_rts_en_i,
    input  logic              tx_done_i,
    input  logic              tx_load_i,
    input  logic              ad_mode_i,
    input  logic              md_en_i,
    input  logic [DATA_W-1:0] tx_char_i,
    output logic              rts_n_o,
    output logic              ad_latched_o,
    output logic [DATA_W:0]   frame_o
);
    logic     rxf_rise;
    logic     rxf_fall;
    rts_req_t rts_req;

    rts_level_edge u_rxf_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (rxf_full_i),
        .rise_o  (rxf_rise),
        .fall_o  (rxf_fall)
    );

    rts_src_decode u_decode (
        .mod_rst_i   (mod_rst_i),
        .set_wr_i    (set_wr_i),
        .clr_wr_i    (clr_wr_i),
        .cmd_valid_i (cmd_valid_i),
        .cmd_i       (cmd_i),
        .rx_rts_en_i (rx_rts_en_i),
        .rxf_rise_i  (rxf_rise),
        .rxf_fall_i  (rxf_fall),
        .tx_rts_en_i (tx_rts_en_i),
        .tx_done_i   (tx_done_i),
        .req_o       (rts_req)
    );

    rts_flag_reg u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (rts_req),
        .rts_n_o (rts_n_o)
    );

    ad_frame_latch #(.DATA_W(DATA_W)) u_ad (
        .clk          (clk),
        .rst_n        (rst_n),
        .mod_rst_i    (mod_rst_i),
        .tx_load_i    (tx_load_i),
        .ad_mode_i    (ad_mode_i),
        .md_en_i      (md_en_i),
        .tx_char_i    (tx_char_i),
        .ad_latched_o (ad_latched_o),
        .frame_o      (frame_o)
    );
endmodule

// File: rtl/uart_rts_addr_chk.sv
// Port-level temporal checks for the RTS and multidrop control block,
// bound to every instance of the top module.
module uart_rts_addr_chk
    import uart_rts_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mod_rst_i,
    input logic              set_wr_i,
    input logic              clr_wr_i,
    input logic              cmd_valid_i,
    input logic [CMD_W-1:0]  cmd_i,
    input logic              rx_rts_en_i,
    input logic              rxf_full_i,
    input logic              tx_rts_en_i,
    input logic              tx_done_i,
    input logic              tx_load_i,
    input logic              ad_mode_i,
    input logic              md_en_i,
    input logic [DATA_W-1:0] tx_char_i,
    input logic              rts_n_o,
    input logic              ad_latched_o,
    input logic [DATA_W:0]   frame_o
);
    logic neg_cmd;
    logic pos_cmd;
    logic other_clr;

    assign neg_cmd   = cmd_valid_i && (cmd_i == CMD_RTS_OFF);
    assign pos_cmd   = cmd_valid_i && (cmd_i == CMD_RTS_ON);
    assign other_clr = clr_wr_i | mod_rst_i | neg_cmd | (tx_rts_en_i & tx_done_i);

    // R1
    mod_rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mod_rst_i |=> (rts_n_o && !ad_latched_o && frame_o == '0));

    // R2
    set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_wr_i || pos_cmd) && !other_clr && !rx_rts_en_i) |=> !rts_n_o);

    // R3
    clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i || neg_cmd) |=> rts_n_o);

    // R4
    rx_full_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rts_en_i && rxf_full_i && !$past(rxf_full_i)) |=> rts_n_o);

    // R5
    rx_drain_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rx_rts_en_i && !rxf_full_i && $past(rxf_full_i) && !other_clr)
        |=> !rts_n_o);

    // R6
    rx_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_rts_en_i && !other_clr && !set_wr_i && !pos_cmd) |=> $stable(rts_n_o));

    // R7
    tx_empty_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_rts_en_i && tx_done_i) |=> rts_n_o);

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wr_i && clr_wr_i) |=> rts_n_o);

    // R9
    ad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_load_i && !mod_rst_i) |=> ($stable(ad_latched_o) && $stable(frame_o)));

    // R10
    frame_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load_i && !mod_rst_i) |=>
        (frame_o == {$past(md_en_i & ad_mode_i), $past(tx_char_i)}
         && ad_latched_o == $past(ad_mode_i)));
endmodule

bind uart_rts_addr_ctl uart_rts_addr_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_uart_rts_addr_ctl.sv
// Self-checking bench: a vector table for the RTS causes, then directed
// tests for reset, module reset and address/data capture.
module tb_uart_rts_addr_ctl;
    localparam int DATA_W = 8;
    localparam int NV = 23;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mod_rst_i = 0, set_wr_i = 0, clr_wr_i = 0, cmd_valid_i = 0;
    logic [2:0] cmd_i = '0;
    logic rx_rts_en_i = 0, rxf_full_i = 0, tx_rts_en_i = 0, tx_done_i = 0;
    logic tx_load_i = 0, ad_mode_i = 0, md_en_i = 0;
    logic [DATA_W-1:0] tx_char_i = '0;
    logic rts_n_o, ad_latched_o;
    logic [DATA_W:0] frame_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    uart_rts_addr_ctl #(.DATA_W(DATA_W)) dut (.*);

    // Vector: {req[3:0], set, clr, cv, cmd[2:0], rxen, full, txen, done, exp_rts_n, pad}
    localparam logic [15:0] VECS [0:NV-1] = '{
        {4'd2,  1'b1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R2 set strobe
        {4'd2,  1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R2 holds
        {4'd3,  1'b0,1'b1,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R3 clr strobe
        {4'd2,  1'b0,1'b0,1'b1,3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R2 assert cmd
        {4'd11, 1'b0,1'b0,1'b1,3'd5,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R11 other code
        {4'd3,  1'b0,1'b0,1'b1,3'd2,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R3 negate cmd
        {4'd2,  1'b1,1'b0,1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0}, // R2 set, rx ctl on
        {4'd4,  1'b0,1'b0,1'b0,3'd0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0}, // R4 fifo fills
        {4'd4,  1'b0,1'b0,1'b0,3'd0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0}, // R4 stays full
        {4'd5,  1'b0,1'b0,1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0}, // R5 fifo drains
        {4'd6,  1'b0,1'b0,1'b0,3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0}, // R6 fill ignored
        {4'd6,  1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R6 drain ignored
        {4'd6,  1'b0,1'b0,1'b0,3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0}, // R6 fill ignored
        {4'd6,  1'b0,1'b0,1'b0,3'd0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0}, // R6 held level, no edge
        {4'd5,  1'b0,1'b0,1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0}, // R5 drain keeps set
        {4'd7,  1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0}, // R7 done, tx ctl off
        {4'd7,  1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0}, // R7 done, tx ctl on
        {4'd8,  1'b1,1'b0,1'b1,3'd2,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R8 set vs negate cmd
        {4'd2,  1'b1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R2 set again
        {4'd8,  1'b1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0}, // R8 set vs tx empty
        {4'd8,  1'b0,1'b0,1'b1,3'd1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0}, // R8 assert cmd vs fill
        {4'd8,  1'b0,1'b1,1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0}, // R8 drain vs clr
        {4'd11, 1'b0,1'b0,1'b0,3'd1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}  // R11 code without valid
    };

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        mod_rst_i = 0; set_wr_i = 0; clr_wr_i = 0; cmd_valid_i = 0; cmd_i = '0;
        rx_rts_en_i = 0; rxf_full_i = 0; tx_rts_en_i = 0; tx_done_i = 0; tx_load_i = 0;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rts_n in reset", {31'd0, rts_n_o}, 1);
        check("R1 ad in reset", {31'd0, ad_latched_o}, 0);
        check("R1 frame in reset", {23'd0, frame_o}, 0);
        rst_n = 1;
        @(negedge clk);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [15:0] v;
            v = VECS[i];
            set_wr_i = v[11]; clr_wr_i = v[10]; cmd_valid_i = v[9]; cmd_i = v[8:6];
            rx_rts_en_i = v[5]; rxf_full_i = v[4]; tx_rts_en_i = v[3]; tx_done_i = v[2];
            @(negedge clk);
            check($sformatf("R%0d vector %0d rts_n", v[15:12], i), {31'd0, rts_n_o}, {31'd0, v[1]});
        end
        idle_inputs();
        @(negedge clk);

        // R9 and R10 capture in multidrop mode
        md_en_i = 1; ad_mode_i = 1; tx_char_i = 8'hA5; tx_load_i = 1;
        @(negedge clk);
        tx_load_i = 0;
        check("R9 ad captured", {31'd0, ad_latched_o}, 1);
        check("R10 multidrop frame", {23'd0, frame_o}, 32'h1A5);
        ad_mode_i = 0; tx_char_i = 8'h3C;
        repeat (2) @(negedge clk);
        check("R9 ad held after mode change", {31'd0, ad_latched_o}, 1);
        check("R9 frame held after mode change", {23'd0, frame_o}, 32'h1A5);
        tx_load_i = 1;
        @(negedge clk);
        tx_load_i = 0;
        check("R9 ad recaptured", {31'd0, ad_latched_o}, 0);
        check("R10 data frame", {23'd0, frame_o}, 32'h03C);
        // R10 multidrop off: ninth bit forced to 0
        md_en_i = 0; ad_mode_i = 1; tx_char_i = 8'h81; tx_load_i = 1;
        @(negedge clk);
        tx_load_i = 0;
        check("R10 plain frame", {23'd0, frame_o}, 32'h081);
        check("R9 ad with multidrop off", {31'd0, ad_latched_o}, 1);

        // R3 and R1 module reset beats set and capture
        set_wr_i = 1;
        @(negedge clk);
        set_wr_i = 0;
        check("R2 set before module reset", {31'd0, rts_n_o}, 0);
        mod_rst_i = 1; set_wr_i = 1; tx_load_i = 1;
        @(negedge clk);
        idle_inputs();
        check("R3 module reset rts_n", {31'd0, rts_n_o}, 1);
        check("R1 module reset ad", {31'd0, ad_latched_o}, 0);
        check("R1 module reset frame", {23'd0, frame_o}, 0);

        // R1 reset in mid-run
        set_wr_i = 1;
        @(negedge clk);
        set_wr_i = 0;
        rst_n = 0;
        @(negedge clk);
        check("R1 rts_n after reset", {31'd0, rts_n_o}, 1);
        rst_n = 1;
        @(negedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule